// File: doc/BRIEF.md
# Multilevel Carrier-Comparison Modulator

This block turns three per-phase duty words into switching states for a three-phase converter with `LEVELS` output levels per phase. Each duty is a fraction from 0 to 1. The block multiplies it by `LEVELS-1` and compares it against a stack of `LEVELS-1` in-phase triangle carriers. Each carrier has unity amplitude, and carrier j spans the band from j-1 to j. A state s stands for a line-to-ground level of s·Vdc/(LEVELS-1). Averaged over a carrier period, the state tracks the scaled duty.

There is only one symmetric up/down counter. All stacked carriers are derived from it: the integer part of the scaled duty picks the band, and the fractional part is compared with the normalised counter value. The duty and half-period inputs are captured only at the carrier valley, so each carrier period uses one consistent set of inputs. The three phase states are also packed into one base-`LEVELS` overall state index, which downstream logic such as a redundant-state selector can use.

Top module: `mlpwm_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, all three phase states and the state index read 0 after that edge. After `rst` falls, the carrier restarts at its valley, so the first edge with `rst` low begins a carrier period.
- R2: The carrier counter rises from 0 to H and falls back to 1, so each period lasts 2·H cycles. H is the `half_period` value captured at the valley, and a `half_period` of 0 is treated as 1.
- R3: A duty word is unsigned, with 1.0 encoded as 2^DUTY_W. The scaled duty S = (LEVELS-1)·d splits into a band k = floor(S/2^DUTY_W) and a fraction f = S mod 2^DUTY_W. With carrier count c, the state after an edge is k+1 when f·H > c·2^DUTY_W, and k otherwise. The output is registered: the state after an edge reflects the carrier value at that edge.
- R4: A duty of 0 yields state 0 in every cycle. A duty of exactly 1.0, or any word above 1.0, yields state LEVELS-1 in every cycle.
- R5: `state_index` equals LEVELS²·state_a + LEVELS·state_b + state_c in the same cycle as the phase states.
- R6: A duty change made after the valley edge has no effect until the next valley. The whole period uses the duty captured at its valley.
- R7: A `half_period` change made after the valley edge has no effect on the current period. It takes effect at the next valley.
- R8: Over one full carrier period, the sum of a phase's states differs from 2·H·S/2^DUTY_W by at most 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_a | input | DUTY_W+1 | Phase A duty, 1.0 = 2^DUTY_W |
| duty_b | input | DUTY_W+1 | Phase B duty |
| duty_c | input | DUTY_W+1 | Phase C duty |
| half_period | input | CNT_W | Carrier half period in cycles (0 acts as 1) |
| state_a | output | $clog2(LEVELS) | Phase A switching state 0..LEVELS-1 |
| state_b | output | $clog2(LEVELS) | Phase B switching state |
| state_c | output | $clog2(LEVELS) | Phase C switching state |
| state_index | output | $clog2(LEVELS³) | Packed base-LEVELS overall state |

## Verification
The hardest case to reach is an input that changes partway through a carrier period, because the effect of the change is deliberately postponed. The bench runs back-to-back periods without resetting between them. It changes a duty or the half period on the cycle just after the valley. It then checks every later cycle of that period against the old value, and checks the next period against the new one. Duty sweeps cover every code at several half periods, including over-range codes and the clamp of a zero half period. This exercises the band boundaries, where the fraction is zero and only the integer part sets the state.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int PHASES = 3;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/mlpwm_carrier.sv
// Symmetric up/down counter shared by every stacked carrier.
module mlpwm_carrier #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] half_period,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] hp_eff,
  output logic             valley
);
  import mlpwm_pkg::*;

  localparam logic [CNT_W-1:0] HP_MIN = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hp_q;
  logic [CNT_W-1:0] hp_in_cl;
  ramp_dir_e        dir_q;

  assign valley   = (cnt_q == '0);
  assign hp_in_cl = (half_period == '0) ? HP_MIN : half_period;
  // The period setting is live only at the valley, held otherwise.
  assign hp_eff   = valley ? hp_in_cl : hp_q;
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hp_q  <= HP_MIN;
      dir_q <= DIR_UP;
    end else begin
      if (valley) begin
        hp_q <= hp_in_cl;
      end
      if (dir_q == DIR_UP) begin
        cnt_q <= cnt_q + HP_MIN;
        if (cnt_q + HP_MIN == hp_eff) begin
          dir_q <= DIR_DOWN;
        end
      end else begin
        cnt_q <= cnt_q - HP_MIN;
        if (cnt_q == HP_MIN) begin
          dir_q <= DIR_UP;
        end
      end
    end
  end
endmodule

// File: rtl/mlpwm_sample_hold.sv
// Captures each duty word at the carrier valley and presents it for the period.
module mlpwm_sample_hold #(
  parameter int W = 13,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valley,
  input  logic [W-1:0] d_in  [N],
  output logic [W-1:0] d_eff [N]
);
  for (genvar g = 0; g < N; g++) begin : g_hold
    logic [W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q <= '0;
      end else if (valley) begin
        hold_q <= d_in[g];
      end
    end
    assign d_eff[g] = valley ? d_in[g] : hold_q;
  end
endmodule

// File: rtl/mlpwm_level_slicer.sv
// Quantises one scaled duty against the stacked carriers.
module mlpwm_level_slicer #(
  parameter int LEVELS = 5,
  parameter int DUTY_W = 12,
  parameter int CNT_W  = 10,
  localparam int SW    = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W:0]   duty,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  hp,
  output logic [SW-1:0]     level_nxt,
  output logic [SW-1:0]     level_q
);
  localparam int SCW = DUTY_W + 1 + SW;
  localparam int KW  = SCW - DUTY_W;
  localparam int PW  = DUTY_W + CNT_W;
  localparam logic [DUTY_W:0] ONE   = {1'b1, {DUTY_W{1'b0}}};
  localparam logic [SCW-1:0]  SCALE = SCW'(LEVELS - 1);
  localparam logic [KW-1:0]   TOP   = KW'(LEVELS - 1);

  logic [DUTY_W:0]   duty_sat;
  logic [SCW-1:0]    scaled;
  logic [KW-1:0]     band;
  logic [DUTY_W-1:0] frac;
  logic [PW-1:0]     frac_x_hp;
  logic [PW-1:0]     cnt_x_one;
  logic              above;
  logic [KW-1:0]     level_raw;

  always_comb begin
    duty_sat  = (duty > ONE) ? ONE : duty;
    scaled    = SCW'(duty_sat) * SCALE;
    band      = scaled[SCW-1:DUTY_W];
    frac      = scaled[DUTY_W-1:0];
    // frac/2^W > cnt/hp, cross-multiplied to avoid a divider
    frac_x_hp = PW'(frac) * PW'(hp);
    cnt_x_one = {cnt, {DUTY_W{1'b0}}};
    above     = frac_x_hp > cnt_x_one;
    level_raw = band + KW'(above);
    level_nxt = (level_raw > TOP) ? TOP[SW-1:0] : level_raw[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else begin
      level_q <= level_nxt;
    end
  end
endmodule

// File: rtl/mlpwm_state_pack.sv
// Packs the three phase states into a base-LEVELS index.
module mlpwm_state_pack #(
  parameter int LEVELS = 5,
  localparam int SW    = $clog2(LEVELS),
  localparam int IW    = $clog2(LEVELS * LEVELS * LEVELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] lv_a,
  input  logic [SW-1:0] lv_b,
  input  logic [SW-1:0] lv_c,
  output logic [IW-1:0] idx_q
);
  localparam logic [IW-1:0] RADIX = IW'(LEVELS);

  logic [IW-1:0] idx_nxt;

  always_comb begin
    idx_nxt = (IW'(lv_a) * RADIX + IW'(lv_b)) * RADIX + IW'(lv_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_nxt;
    end
  end
endmodule

// File: rtl/mlpwm_modulator.sv
module mlpwm_modulator #(
  parameter int LEVELS = 5,
  parameter int DUTY_W = 12,
  parameter int CNT_W  = 10,
  localparam int SW    = $clog2(LEVELS),
  localparam int IW    = $clog2(LEVELS * LEVELS * LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W:0]   duty_a,
  input  logic [DUTY_W:0]   duty_b,
  input  logic [DUTY_W:0]   duty_c,
  input  logic [CNT_W-1:0]  half_period,
  output logic [SW-1:0]     state_a,
  output logic [SW-1:0]     state_b,
  output logic [SW-1:0]     state_c,
  output logic [IW-1:0]     state_index
);
  import mlpwm_pkg::*;

  logic [CNT_W-1:0] car_cnt;
  logic [CNT_W-1:0] car_hp;
  logic             valley;
  logic [DUTY_W:0]  duty_in  [PHASES];
  logic [DUTY_W:0]  duty_eff [PHASES];
  logic [SW-1:0]    lv_nxt   [PHASES];
  logic [SW-1:0]    lv_q     [PHASES];

  assign duty_in[0] = duty_a;
  assign duty_in[1] = duty_b;
  assign duty_in[2] = duty_c;

  mlpwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk         (clk),
    .rst         (rst),
    .half_period (half_period),
    .cnt         (car_cnt),
    .hp_eff      (car_hp),
    .valley      (valley)
  );

  mlpwm_sample_hold #(.W(DUTY_W + 1), .N(PHASES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .valley (valley),
    .d_in   (duty_in),
    .d_eff  (duty_eff)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    mlpwm_level_slicer #(
      .LEVELS (LEVELS),
      .DUTY_W (DUTY_W),
      .CNT_W  (CNT_W)
    ) u_slice (
      .clk       (clk),
      .rst       (rst),
      .duty      (duty_eff[p]),
      .cnt       (car_cnt),
      .hp        (car_hp),
      .level_nxt (lv_nxt[p]),
      .level_q   (lv_q[p])
    );
  end

  mlpwm_state_pack #(.LEVELS(LEVELS)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .lv_a  (lv_nxt[0]),
    .lv_b  (lv_nxt[1]),
    .lv_c  (lv_nxt[2]),
    .idx_q (state_index)
  );

  assign state_a = lv_q[0];
  assign state_b = lv_q[1];
  assign state_c = lv_q[2];
endmodule

// File: rtl/mlpwm_modulator_chk.sv
module mlpwm_modulator_chk #(
  parameter int LEVELS = 5,
  parameter int CNT_W  = 10,
  localparam int SW    = $clog2(LEVELS),
  localparam int IW    = $clog2(LEVELS * LEVELS * LEVELS)
) (
  input logic             clk,
  input logic             rst,
  input logic [SW-1:0]    state_a,
  input logic [SW-1:0]    state_b,
  input logic [SW-1:0]    state_c,
  input logic [IW-1:0]    state_index,
  input logic [CNT_W-1:0] car_cnt,
  input logic [CNT_W-1:0] car_hp
);
  localparam logic [SW-1:0] TOPS  = SW'(LEVELS - 1);
  localparam logic [IW-1:0] RADIX = IW'(LEVELS);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state_a == '0 && state_b == '0 && state_c == '0 && state_index == '0));

  p_carrier_bound_r2: assert property (@(posedge clk) disable iff (rst)
    car_cnt <= car_hp);

  p_valley_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (car_cnt == '0) |=> (car_cnt == CNT_W'(1)));

  p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
    (state_a <= TOPS) && (state_b <= TOPS) && (state_c <= TOPS));

  p_index_pack_r5: assert property (@(posedge clk) disable iff (rst)
    state_index == (IW'(state_a) * RADIX + IW'(state_b)) * RADIX + IW'(state_c));
endmodule

bind mlpwm_modulator mlpwm_modulator_chk #(
  .LEVELS (LEVELS),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .state_a     (state_a),
  .state_b     (state_b),
  .state_c     (state_c),
  .state_index (state_index),
  .car_cnt     (car_cnt),
  .car_hp      (car_hp)
);

// File: tb/mlpwm_modulator_tb_top.sv
module mlpwm_modulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int W   = 6;
  localparam int CW  = 6;
  localparam int SW  = 2;
  localparam int IW  = 6;
  localparam int ONE = 1 << W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W:0]    duty_a = '0;
  logic [W:0]    duty_b = '0;
  logic [W:0]    duty_c = '0;
  logic [CW-1:0] half_period = '0;
  logic [SW-1:0] state_a, state_b, state_c;
  logic [IW-1:0] state_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mlpwm_modulator #(.LEVELS(N), .DUTY_W(W), .CNT_W(CW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .duty_a      (duty_a),
    .duty_b      (duty_b),
    .duty_c      (duty_c),
    .half_period (half_period),
    .state_a     (state_a),
    .state_b     (state_b),
    .state_c     (state_c),
    .state_index (state_index)
  );

  function automatic int exp_level(int duty, int h, int c);
    int d, s, k, f, lv;
    d  = (duty > ONE) ? ONE : duty;
    s  = d * (N - 1);
    k  = s / ONE;
    f  = s % ONE;
    lv = k + (((f * h) > (c * ONE)) ? 1 : 0);
    if (lv > N - 1) lv = N - 1;
    return lv;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered just after a negedge, with the next posedge being a valley.
  task automatic run_period(int da, int db, int dc, int hp,
                            int mid_duty, int mid_hp, string tag);
    int h, sum, ea, eb, ec, ei, c, dsat, diff;
    h   = (hp == 0) ? 1 : hp;
    sum = 0;
    duty_a      = da[W:0];
    duty_b      = db[W:0];
    duty_c      = dc[W:0];
    half_period = hp[CW-1:0];
    for (int i = 0; i < 2 * h; i++) begin
      @(posedge clk);
      @(negedge clk);
      c  = (i <= h) ? i : 2 * h - i;
      ea = exp_level(da, h, c);
      eb = exp_level(db, h, c);
      ec = exp_level(dc, h, c);
      ei = ea * N * N + eb * N + ec;
      check(int'(state_a) == ea, {tag, " level a"}, int'(state_a), ea);
      check(int'(state_b) == eb, {tag, " level b"}, int'(state_b), eb);
      check(int'(state_c) == ec, {tag, " level c"}, int'(state_c), ec);
      check(int'(state_index) == ei, "R5 packed index", int'(state_index), ei);
      sum += int'(state_a);
      if (i == 0 && mid_duty >= 0) duty_a = mid_duty[W:0];
      if (i == 0 && mid_hp >= 0) half_period = mid_hp[CW-1:0];
    end
    dsat = ((da > ONE) ? ONE : da) * (N - 1);
    diff = sum * ONE - 2 * h * dsat;
    if (diff < 0) diff = -diff;
    check(diff <= ONE, "R8 period average", sum * ONE, 2 * h * dsat);
  endtask

  initial begin
    duty_a = 7'd40; duty_b = 7'd50; duty_c = 7'd64;
    half_period = 6'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(state_a == '0, "R1 reset a", int'(state_a), 0);
    check(state_b == '0, "R1 reset b", int'(state_b), 0);
    check(state_c == '0, "R1 reset c", int'(state_c), 0);
    check(state_index == '0, "R1 reset index", int'(state_index), 0);
    rst = 1'b0;

    // R3: full sweep of in-range duty codes at several half periods
    for (int hsel = 0; hsel < 3; hsel++) begin
      for (int d = 0; d <= ONE; d++) begin
        run_period(d, (d * 5) % (ONE + 1), (d * 11 + 3) % (ONE + 1),
                   (hsel == 0) ? 1 : ((hsel == 1) ? 2 : 5), -1, -1, "R3");
      end
    end

    // R4: extremes and over-range codes
    run_period(0, 0, 0, 4, -1, -1, "R4");
    run_period(ONE, ONE, ONE, 4, -1, -1, "R4");
    for (int d = ONE + 1; d < 2 * ONE; d += 9) begin
      run_period(d, 2 * ONE - 1, 0, 3, -1, -1, "R4");
    end

    // R2: zero half period clamps to one; the longest period
    run_period(20, 30, 40, 0, -1, -1, "R2");
    run_period(21, 43, 59, (1 << CW) - 1, -1, -1, "R2");

    // R6: duty change just after the valley is deferred one period
    run_period(10, 20, 30, 4, 60, -1, "R6");
    run_period(60, 20, 30, 4, -1, -1, "R6");

    // R7: half-period change just after the valley is deferred one period
    run_period(33, 33, 33, 3, -1, 6, "R7");
    run_period(33, 33, 33, 6, -1, -1, "R7");

    // R1: reset in the middle of a run, then restart at a valley
    duty_a = 7'd50; duty_b = 7'd50; duty_c = 7'd50;
    half_period = 6'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(state_a == '0 && state_b == '0 && state_c == '0, "R1 mid-run reset",
          int'(state_a), 0);
    check(state_index == '0, "R1 mid-run reset index", int'(state_index), 0);
    rst = 1'b0;
    run_period(50, 17, 63, 4, -1, -1, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule